// File: doc/BRIEF.md
# UART Bit-Rate Enable Generator

This block turns the system clock into the two timing strobes a full-duplex serial port needs. The clock runs through two dividers in series. The first is a prescaler whose factor is set by a 5-bit code and moves in steps of one half. The second is a programmable divisor counter. Each time the divisor counter wraps, the block raises a one-cycle sample enable, which the receiver uses as its 16x oversampling strobe. Every sixteenth sample enable coincides with a one-cycle bit enable, which paces the transmitter and marks bit boundaries.

A half-step factor k+0.5 comes from prescaler periods that alternate between k and k+1 input cycles. Over any two periods the average is exact. Software programs the block through two write strobes, one for the prescaler code and one for the divisor. Any write clears all counting state, so the new rate begins cleanly on the next clock. After reset the prescaler code is zero and the block emits nothing.

Top module: `baud_clock_gen`

## Requirements
- R1: While reset is asserted and after it is released, `os_tick` and `bit_tick` are 0 and stay 0 until a non-zero prescaler code is written.
- R2: While the prescaler code is 0, neither `os_tick` nor `bit_tick` is ever asserted, whatever the divisor value.
- R3: Prescaler code c (1..31) selects a factor of (c+1)/2, so code 1 gives 1, code 2 gives 1.5, code 3 gives 2, and each further code adds 0.5.
- R4: With an odd code c (integer factor k=(c+1)/2) and divisor N, `os_tick` is high for one cycle every k*N cycles. The first pulse comes in cycle k*N-1 after the write edge, counting the first cycle after that edge as cycle 0.
- R5: With an even code c (factor k+0.5, k=c/2), prescaler periods alternate between k and k+1 cycles, starting with k after a restart. With divisor 1, `os_tick` intervals alternate between k+1 and k after a first pulse in cycle k-1. With divisor 2, pulses come every c+1 cycles.
- R6: A divisor value of 0 behaves exactly like a divisor of 1.
- R7: `bit_tick` is high only together with `os_tick`, on every sixteenth `os_tick` counted from a restart, so its first pulse comes in cycle 16*k*N-1.
- R8: A write to either the prescaler code (`sel_wr`) or the divisor (`div_wr`) loads the new value and restarts the prescaler, the divisor counter and the sixteen-count on the clock edge that samples the strobe. This holds even when the write lands in a cycle with a pending `os_tick`.
- R9: The largest settings work: code 31 (factor 16) with divisor 1023 gives an `os_tick` interval of 16368 cycles, and code 30 (factor 15.5) with divisor 2 gives 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_wr | input | 1 | Write strobe for the prescaler code |
| sel_wdata | input | 5 | New prescaler code |
| div_wr | input | 1 | Write strobe for the divisor |
| div_wdata | input | 10 | New divisor value (0 acts as 1) |
| os_tick | output | 1 | One-cycle 16x oversample enable |
| bit_tick | output | 1 | One-cycle bit-rate enable |

## Verification
Two events can fall in the same cycle: a register write restarts the counters, and the sixteen-count is about to carry into a bit enable. The bench lets fifteen sample enables pass and then issues a divisor write in the cycle where the sixteenth is showing. A correct design must clear the sixteen-count. The next sample enable then arrives one full period later with no bit enable, and the first bit enable comes only after sixteen more periods. Half-step factors are judged by the alternating gaps between sample enables.

// File: rtl/baud_pkg.sv
// Shared widths for the bit-rate enable generator.
package baud_pkg;
    localparam int SEL_W   = 5;   // prescaler code width
    localparam int DIV_W   = 10;  // divisor width
    localparam int OVS_CNT = 16;  // sample enables per bit
    localparam int OVS_W   = $clog2(OVS_CNT) + 1;
endpackage

// File: rtl/baud_prescaler.sv
// Half-step prescaler. Code c>0 gives factor (c+1)/2. Even codes alternate
// periods of k and k+1 cycles (k=c/2), starting with k. Code 0 holds idle.
// Assumes restart is a single-cycle strobe and that sel is stable between restarts.
module baud_prescaler #(
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = SEL_W + 1;

    logic [CW-1:0] cnt;
    logic          phase;
    logic [CW-1:0] base_len;
    logic [CW-1:0] cur_len;
    logic          half_step;
    logic          run;

    // Period length for the current phase.
    always_comb begin
        run       = (sel != '0);
        half_step = ~sel[0];
        base_len  = ({1'b0, sel} + CW'(1)) >> 1;
        cur_len   = base_len + CW'(half_step & phase);
        tick      = run && (cnt == cur_len - CW'(1));
    end

    // Count input cycles and flip the phase at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/baud_counter.sv
// Modulo counter that advances on step and wraps at limit. wrap is high in the
// step cycle that completes a count. Assumes limit >= 1.
module baud_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt;

    // Flag the last step of the count.
    assign wrap = step && (cnt == limit - W'(1));

    // Advance the count on each step and clear it on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/baud_clock_gen.sv
// Bit-rate enable generator: prescaler, divisor counter and sixteen-count in
// series. Any register write restarts all three stages. Assumes the write
// strobes are synchronous to clk.
module baud_clock_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             os_tick,
    output logic             bit_tick
);
    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic             restart;
    logic             pre_tick;
    logic             div_wrap;
    logic             ovs_wrap;

    // Any register write restarts the chain.
    assign restart = sel_wr | div_wr;

    // A zero divisor counts as one.
    assign div_lim = (div_q == '0) ? DIV_W'(1) : div_q;

    // Hold the programmed prescaler code and divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            div_q <= '0;
        end else begin
            if (sel_wr) sel_q <= sel_wdata;
            if (div_wr) div_q <= div_wdata;
        end
    end

    baud_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sel     (sel_q),
        .tick    (pre_tick)
    );

    baud_counter #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .step  (pre_tick),
        .limit (div_lim),
        .wrap  (div_wrap)
    );

    baud_counter #(.W(OVS_W)) u_ovs (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .step  (div_wrap),
        .limit (OVS_W'(OVS_CNT)),
        .wrap  (ovs_wrap)
    );

    assign os_tick  = div_wrap;
    assign bit_tick = ovs_wrap;
endmodule

// File: rtl/baud_clock_gen_checker.sv
// Temporal checks on the bit-rate enable generator, bound to its top module.
module baud_clock_gen_checker #(
    parameter int SEL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_wr,
    input logic             div_wr,
    input logic [SEL_W-1:0] sel_q,
    input logic             os_tick,
    input logic             bit_tick
);
    logic [4:0] seen;

    // Count sample enables since the last bit enable or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_wr || div_wr) seen <= '0;
        else if (bit_tick)              seen <= '0;
        else if (os_tick)               seen <= seen + 5'd1;
    end

    assert_bit_with_os_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    assert_bit_on_sixteenth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (seen == 5'd15));

    assert_sixteenth_gives_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && seen == 5'd15 && !sel_wr && !div_wr) |-> bit_tick);

    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |-> (!os_tick && !bit_tick));

    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr || div_wr) |=> !bit_tick);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!os_tick && !bit_tick));
endmodule

bind baud_clock_gen baud_clock_gen_checker #(.SEL_W(baud_pkg::SEL_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_wr   (sel_wr),
    .div_wr   (div_wr),
    .sel_q    (sel_q),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
);

// File: tb/baud_clock_gen_test.sv
// Directed bench for the bit-rate enable generator.
module baud_clock_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [4:0] sel_wdata = '0;
    logic       div_wr = 1'b0;
    logic [9:0] div_wdata = '0;
    logic       os_tick;
    logic       bit_tick;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    baud_clock_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .os_tick   (os_tick),
        .bit_tick  (bit_tick)
    );

    always #2 clk = ~clk;  // 250 MHz

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write helpers end at the negedge of cycle 0 after the write edge.
    task automatic write_sel(input logic [4:0] v);
        @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
        @(posedge clk);
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic write_div(input logic [9:0] v);
        @(negedge clk); div_wr = 1'b1; div_wdata = v;
        @(posedge clk);
        @(negedge clk); div_wr = 1'b0;
    endtask

    // Cycles from the current negedge until os_tick is seen (0 if now).
    task automatic find_os(output int idx);
        idx = 0;
        while (!os_tick && idx < 40000) begin
            @(negedge clk); idx++;
        end
    endtask

    // Gap to the next os_tick, stepping past the current one.
    task automatic next_os(output int gap);
        int s;
        @(negedge clk);
        find_os(s);
        gap = s + 1;
    endtask

    task automatic count_ticks(input int n, output int os_n, output int bit_n);
        os_n = 0; bit_n = 0;
        for (int i = 0; i < n; i++) begin
            if (os_tick) os_n++;
            if (bit_tick) bit_n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int o, b;
        @(negedge clk);
        chk("R1 os_tick in reset", os_tick, 0);
        chk("R1 bit_tick in reset", bit_tick, 0);
        rst_n = 1'b1;
        count_ticks(200, o, b);
        chk("R1 os ticks after reset", o, 0);
        chk("R1 bit ticks after reset", b, 0);
    endtask

    task automatic t_idle;
        int o, b;
        write_sel(5'd1);
        write_div(10'd3);
        write_sel(5'd0);
        count_ticks(200, o, b);
        chk("R2 os ticks with code 0", o, 0);
        chk("R2 bit ticks with code 0", b, 0);
    endtask

    task automatic t_integer;
        int f, g;
        write_div(10'd1);
        write_sel(5'd1);
        find_os(f);
        chk("R3 code1 first os", f, 0);
        next_os(g);
        chk("R3 code1 os interval", g, 1);
        write_div(10'd2);
        write_sel(5'd5);
        find_os(f);
        chk("R4 code5 N2 first os", f, 5);
        next_os(g);
        chk("R4 code5 N2 interval", g, 6);
        write_sel(5'd3);
        find_os(f);
        chk("R3 code3 N2 first os", f, 3);
    endtask

    task automatic t_frac;
        int f, g;
        write_div(10'd1);
        write_sel(5'd4);
        find_os(f);
        chk("R5 code4 first os", f, 1);
        next_os(g); chk("R5 code4 gap a", g, 3);
        next_os(g); chk("R5 code4 gap b", g, 2);
        next_os(g); chk("R5 code4 gap c", g, 3);
        write_sel(5'd2);
        find_os(f);
        chk("R5 code2 first os", f, 0);
        next_os(g); chk("R5 code2 gap a", g, 2);
        next_os(g); chk("R5 code2 gap b", g, 1);
        write_div(10'd2);
        write_sel(5'd4);
        find_os(f);
        chk("R5 code4 N2 first os", f, 4);
        next_os(g); chk("R5 code4 N2 gap", g, 5);
    endtask

    task automatic t_zero_div;
        int f, g;
        write_sel(5'd3);
        write_div(10'd0);
        find_os(f);
        chk("R6 div0 first os", f, 1);
        next_os(g);
        chk("R6 div0 interval", g, 2);
    endtask

    task automatic t_bit;
        int f, g, o, b;
        write_div(10'd1);
        write_sel(5'd1);
        f = 0;
        while (!bit_tick && f < 1000) begin @(negedge clk); f++; end
        chk("R7 first bit_tick cycle", f, 15);
        chk("R7 os with bit", os_tick, 1);
        @(negedge clk);
        count_ticks(16, o, b);
        chk("R7 os per bit", o, 16);
        chk("R7 bits per 16 os", b, 1);
    endtask

    task automatic t_max;
        int f, g;
        write_div(10'd1023);
        write_sel(5'd31);
        find_os(f);
        chk("R9 max first os", f, 16367);
        next_os(g);
        chk("R9 max interval", g, 16368);
        write_div(10'd2);
        write_sel(5'd30);
        find_os(f);
        chk("R9 code30 first os", f, 30);
        next_os(g);
        chk("R9 code30 interval", g, 31);
    endtask

    task automatic t_restart;
        int f, seen, bf;
        write_div(10'd4);
        write_sel(5'd5);
        repeat (5) @(negedge clk);
        write_div(10'd4);
        find_os(f);
        chk("R8 restart mid-count first os", f, 11);
        write_sel(5'd1);
        seen = 0;
        while (seen < 15) begin
            @(negedge clk);
            if (os_tick) seen++;
        end
        @(negedge clk);
        while (!os_tick) @(negedge clk);
        div_wr = 1'b1; div_wdata = 10'd4;
        @(posedge clk);
        @(negedge clk); div_wr = 1'b0;
        find_os(f);
        chk("R8 collision next os", f, 3);
        chk("R8 collision no bit", bit_tick, 0);
        bf = f;
        while (!bit_tick && bf < 1000) begin @(negedge clk); bf++; end
        chk("R8 collision first bit", bf, 63);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_idle();
        t_integer();
        t_frac();
        t_zero_div();
        t_bit();
        t_restart();
        t_max();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule